// File: doc/BRIEF.md
# Configurable Reset Source Controller

This block merges five reset causes into one registered system reset for the rest of the chip. The causes are a power-on pulse, a brown-out pulse, an external active-low master-clear pin, a watchdog timeout strobe and a stack overflow or underflow strobe. Supply detection is done elsewhere, so power-on and brown-out arrive here as single-cycle digital pulses. The watchdog counter is also kept outside this block.

Static configuration inputs decide three things. The first is whether the external pin resets the chip or serves as a plain digital input. That choice is only honoured while low-voltage programming is enabled. The second is whether a power-up delay follows power-on and brown-out events, and this enable is active-low. The third is whether stack faults reset the chip. Two sticky flags record stack overflow and stack underflow events, whether or not the stack fault is allowed to cause a reset.

The system reset rises on the clock edge that samples any active source. It falls on the first edge at which no source is active and no power-up delay is running. The external pin first passes through a synchronizer of `SYNC_STAGES` flops.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1 and both stack flags are 0.
- R2: A 1 on `por_i`, `bor_i` or `wdt_to_i` sampled at a rising clock edge makes `sys_rst_o` 1 after that edge.
- R3: The pin has the reset role when `cfg_lvp_i` is 0 or `cfg_pin_rst_i` is 1. In that role, each cycle `mclr_ni` is low holds `sys_rst_o` high for one cycle, seen `SYNC_STAGES` cycles later.
- R4: The pin has the digital-input role when `cfg_lvp_i` is 1 and `cfg_pin_rst_i` is 0. In that role, `mclr_ni` never affects `sys_rst_o`, and `pin_data_o` shows the synchronized pin level. `pin_data_o` is 0 in the reset role.
- R5: `pin_pullup_o` is 1 in the reset role and equals `pin_wpu_i` in the digital-input role.
- R6: With `cfg_pwrup_dis_i` = 0, a single-cycle power-on or brown-out pulse holds `sys_rst_o` high for exactly `PWRUP_CYCLES`+1 cycles.
- R7: With `cfg_pwrup_dis_i` = 1, a single-cycle power-on or brown-out pulse holds `sys_rst_o` high for exactly 1 cycle.
- R8: Master-clear and watchdog resets never start the power-up delay, even when it is enabled.
- R9: A 1 on `stk_ovf_i` or `stk_unf_i` sets `stk_ovf_flag_o` or `stk_unf_flag_o` on the next edge, whatever the value of `cfg_stk_rst_i`, unless a clear occurs in the same cycle.
- R10: A stack event resets the system for one cycle only when `cfg_stk_rst_i` is 1. When it is 0, the event leaves `sys_rst_o` at 0.
- R11: The flags are cleared only by `por_i` or `flag_clr_i`, and a clear wins over a set in the same cycle. Brown-out, watchdog and pin resets leave the flags unchanged.
- R12: A power-on or brown-out pulse that arrives during a running delay restarts the full `PWRUP_CYCLES` count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's own flops |
| por_i | input | 1 | Power-on event pulse |
| bor_i | input | 1 | Brown-out event pulse |
| mclr_ni | input | 1 | External master-clear pin level, active low |
| wdt_to_i | input | 1 | Watchdog timeout strobe |
| stk_ovf_i | input | 1 | Stack overflow strobe |
| stk_unf_i | input | 1 | Stack underflow strobe |
| flag_clr_i | input | 1 | Software clear of the stack flags |
| cfg_lvp_i | input | 1 | Low-voltage programming enabled |
| cfg_pin_rst_i | input | 1 | Pin function: 1 = reset, 0 = digital input |
| cfg_pwrup_dis_i | input | 1 | Power-up delay, active-low enable (0 = delay on) |
| cfg_stk_rst_i | input | 1 | 1 = stack faults cause reset |
| pin_wpu_i | input | 1 | Per-pin pull-up enable for the digital-input role |
| sys_rst_o | output | 1 | System reset, active high, registered |
| pin_pullup_o | output | 1 | Weak pull-up enable for the pin |
| pin_data_o | output | 1 | Synchronized pin level in the digital-input role |
| stk_ovf_flag_o | output | 1 | Sticky stack overflow flag |
| stk_unf_flag_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest situation to reach is a second supply event that lands in the middle of a running power-up delay. It must reload the count rather than let the old count finish. The stimulus first issues a power-on pulse, waits a few cycles and then issues a brown-out pulse. It then measures the remaining reset length against a full delay plus one. A second hard case is a flag clear and a flag set in the same cycle. Both strobes are driven together, and the bench confirms that the flag reads 0 afterwards.

// File: rtl/reset_src_pkg.sv
package reset_src_pkg;

  typedef struct packed {
    logic supply_on;
    logic supply_low;
    logic pin;
    logic watchdog;
    logic stack;
  } rst_req_t;

  function automatic logic req_any(rst_req_t r);
    return |r;
  endfunction

endpackage

// File: rtl/rsc_pin_ctrl.sv
module rsc_pin_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic cfg_lvp_i,
  input  logic cfg_pin_rst_i,
  input  logic pin_wpu_i,
  output logic pin_rst_req_o,
  output logic pin_pullup_o,
  output logic pin_data_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_lvl;
  logic                   role_rst;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_ni;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      end
    end
  endgenerate

  assign pin_lvl = sync_q[SYNC_STAGES-1];

  // selection bit only honoured when low-voltage programming is on
  assign role_rst      = !cfg_lvp_i || cfg_pin_rst_i;
  assign pin_rst_req_o = role_rst && !pin_lvl;
  assign pin_pullup_o  = role_rst ? 1'b1 : pin_wpu_i;
  assign pin_data_o    = role_rst ? 1'b0 : pin_lvl;

endmodule

// File: rtl/rsc_pwrup_timer.sv
module rsc_pwrup_timer #(
  parameter int CYCLES = 72000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic enable_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= enable_i ? LOAD : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/rsc_stack_flags.sv
module rsc_stack_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic unf_i,
  input  logic clr_i,
  output logic ovf_flag_o,
  output logic unf_flag_o
);

  logic [1:0] evt;
  logic [1:0] flag_q;

  assign evt = {unf_i, ovf_i};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     flag_q[i] <= 1'b0;
        else if (clr_i)  flag_q[i] <= 1'b0;  // clear wins
        else if (evt[i]) flag_q[i] <= 1'b1;
      end
    end
  endgenerate

  assign ovf_flag_o = flag_q[0];
  assign unf_flag_o = flag_q[1];

endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import reset_src_pkg::*;
#(
  parameter int PWRUP_CYCLES = 72000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic bor_i,
  input  logic mclr_ni,
  input  logic wdt_to_i,
  input  logic stk_ovf_i,
  input  logic stk_unf_i,
  input  logic flag_clr_i,
  input  logic cfg_lvp_i,
  input  logic cfg_pin_rst_i,
  input  logic cfg_pwrup_dis_i,
  input  logic cfg_stk_rst_i,
  input  logic pin_wpu_i,
  output logic sys_rst_o,
  output logic pin_pullup_o,
  output logic pin_data_o,
  output logic stk_ovf_flag_o,
  output logic stk_unf_flag_o
);

  rst_req_t req;
  logic     pin_req;
  logic     pwrup_busy;
  logic     sys_rst_q;

  rsc_pin_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_ni       (mclr_ni),
    .cfg_lvp_i    (cfg_lvp_i),
    .cfg_pin_rst_i(cfg_pin_rst_i),
    .pin_wpu_i    (pin_wpu_i),
    .pin_rst_req_o(pin_req),
    .pin_pullup_o (pin_pullup_o),
    .pin_data_o   (pin_data_o)
  );

  // only supply events start the delay
  rsc_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (por_i || bor_i),
    .enable_i(!cfg_pwrup_dis_i),
    .busy_o  (pwrup_busy)
  );

  rsc_stack_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_i     (stk_ovf_i),
    .unf_i     (stk_unf_i),
    .clr_i     (por_i || flag_clr_i),
    .ovf_flag_o(stk_ovf_flag_o),
    .unf_flag_o(stk_unf_flag_o)
  );

  always_comb begin
    req.supply_on  = por_i;
    req.supply_low = bor_i;
    req.pin        = pin_req;
    req.watchdog   = wdt_to_i;
    req.stack      = cfg_stk_rst_i && (stk_ovf_i || stk_unf_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_rst_q <= 1'b1;
    else         sys_rst_q <= req_any(req) || pwrup_busy;
  end

  assign sys_rst_o = sys_rst_q;

endmodule

// File: rtl/reset_source_ctrl_chk.sv
module reset_source_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_i,
  input logic bor_i,
  input logic wdt_to_i,
  input logic stk_ovf_i,
  input logic stk_unf_i,
  input logic flag_clr_i,
  input logic cfg_lvp_i,
  input logic cfg_pin_rst_i,
  input logic cfg_stk_rst_i,
  input logic pin_wpu_i,
  input logic sys_rst_o,
  input logic pin_pullup_o,
  input logic stk_ovf_flag_o,
  input logic stk_unf_flag_o
);

  p_src_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i || wdt_to_i) |=> sys_rst_o);

  p_stk_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stk_rst_i && (stk_ovf_i || stk_unf_i)) |=> sys_rst_o);

  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_ovf_i && !por_i && !flag_clr_i) |=> stk_ovf_flag_o);

  p_unf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_unf_i && !por_i && !flag_clr_i) |=> stk_unf_flag_o);

  p_flag_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || flag_clr_i) |=> (!stk_ovf_flag_o && !stk_unf_flag_o));

  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !flag_clr_i && !stk_ovf_i) |=> $stable(stk_ovf_flag_o));

  p_pullup_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_lvp_i || cfg_pin_rst_i) |-> pin_pullup_o);

  p_pullup_gpio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_lvp_i && !cfg_pin_rst_i) |-> (pin_pullup_o == pin_wpu_i));

endmodule

bind reset_source_ctrl reset_source_ctrl_chk u_chk (.*);

// File: tb/reset_source_ctrl_bench.sv
module reset_source_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_DLY      = 20;
  localparam int N_SYNC     = 2;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic por_i = 0, bor_i = 0, mclr_ni = 1, wdt_to_i = 0;
  logic stk_ovf_i = 0, stk_unf_i = 0, flag_clr_i = 0;
  logic cfg_lvp_i = 0, cfg_pin_rst_i = 1, cfg_pwrup_dis_i = 1, cfg_stk_rst_i = 0;
  logic pin_wpu_i = 0;
  logic sys_rst_o, pin_pullup_o, pin_data_o, stk_ovf_flag_o, stk_unf_flag_o;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0, cmp_en = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  reset_source_ctrl #(.PWRUP_CYCLES(N_DLY), .SYNC_STAGES(N_SYNC)) u_reset_source_ctrl (.*);

  // behavioural reference model
  int m_cnt = 0;
  bit m_rst = 1, m_ovf = 0, m_unf = 0;
  bit m_q[$] = '{1, 1};

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_rst = 1; m_ovf = 0; m_unf = 0;
      m_q = '{1, 1};
    end else begin
      bit role, any;
      role = !cfg_lvp_i || cfg_pin_rst_i;
      any = por_i || bor_i || wdt_to_i || (m_cnt != 0)
         || (cfg_stk_rst_i && (stk_ovf_i || stk_unf_i))
         || (role && !m_q[$]);
      m_rst = any;
      if (por_i || bor_i) m_cnt = cfg_pwrup_dis_i ? 0 : N_DLY;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (por_i || flag_clr_i) begin m_ovf = 0; m_unf = 0; end
      else begin
        if (stk_ovf_i) m_ovf = 1;
        if (stk_unf_i) m_unf = 1;
      end
      m_q.push_front(mclr_ni);
      void'(m_q.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      bit role;
      role = !cfg_lvp_i || cfg_pin_rst_i;
      chk({cur_tag, " sys_rst"}, sys_rst_o, m_rst);
      chk("R9 ovf_flag", stk_ovf_flag_o, m_ovf);
      chk("R9 unf_flag", stk_unf_flag_o, m_unf);
      chk("R5 pullup", pin_pullup_o, role ? 1 : pin_wpu_i);
      chk("R4 pin_data", pin_data_o, role ? 0 : m_q[$]);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  // count consecutive intervals with sys_rst_o high, waiting briefly for a rise
  task automatic measure(output int n);
    int w = 0;
    n = 0;
    while (!sys_rst_o && w < 8) begin step(); w++; end
    while (sys_rst_o && n < 200) begin n++; step(); end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    rst_ni = 1'b0;
    step(3);
    chk("R1 sys_rst in reset", sys_rst_o, 1);
    chk("R1 ovf_flag in reset", stk_ovf_flag_o, 0);
    rst_ni = 1'b1;
    step(2);
    cmp_en = 1;

    cur_tag = "R6";
    cfg_pwrup_dis_i = 0;
    por_i = 1; step(); por_i = 0;
    measure(len); chk("R6 por delay length", len, N_DLY + 1);
    bor_i = 1; step(); bor_i = 0;
    measure(len); chk("R6 bor delay length", len, N_DLY + 1);

    cur_tag = "R7";
    cfg_pwrup_dis_i = 1;
    por_i = 1; step(); por_i = 0;
    measure(len); chk("R7 por no delay", len, 1);
    bor_i = 1; step(); bor_i = 0;
    measure(len); chk("R7 bor no delay", len, 1);

    cur_tag = "R8";
    cfg_pwrup_dis_i = 0;
    wdt_to_i = 1; step(); wdt_to_i = 0;
    measure(len); chk("R8 R2 wdt length", len, 1);
    mclr_ni = 0; step(3); mclr_ni = 1;
    measure(len); chk("R8 R3 mclr length", len, 3);

    cur_tag = "R3";
    cfg_lvp_i = 0; cfg_pin_rst_i = 0;
    mclr_ni = 0; step(2); mclr_ni = 1;
    measure(len); chk("R3 lvp off forces reset role", len, 2);

    cur_tag = "R4";
    cfg_lvp_i = 1; cfg_pin_rst_i = 0; pin_wpu_i = 1;
    mclr_ni = 0; step(N_SYNC + 1);
    chk("R4 pin_data low", pin_data_o, 0);
    chk("R4 no reset from pin", sys_rst_o, 0);
    chk("R5 pullup follows wpu 1", pin_pullup_o, 1);
    pin_wpu_i = 0; step();
    chk("R5 pullup follows wpu 0", pin_pullup_o, 0);
    mclr_ni = 1; step(N_SYNC + 1);
    chk("R4 pin_data high", pin_data_o, 1);
    cfg_pin_rst_i = 1; step();
    chk("R5 pullup in reset role", pin_pullup_o, 1);
    chk("R4 pin_data zero in reset role", pin_data_o, 0);

    cur_tag = "R10";
    cfg_stk_rst_i = 0;
    stk_ovf_i = 1; step(); stk_ovf_i = 0;
    chk("R10 no reset when disabled", sys_rst_o, 0);
    chk("R9 ovf flag set while reset disabled", stk_ovf_flag_o, 1);
    step();
    cfg_stk_rst_i = 1;
    stk_unf_i = 1; step(); stk_unf_i = 0;
    chk("R10 reset when enabled", sys_rst_o, 1);
    chk("R9 unf flag set", stk_unf_flag_o, 1);
    step();
    chk("R10 reset released", sys_rst_o, 0);

    cur_tag = "R11";
    cfg_pwrup_dis_i = 1;
    bor_i = 1; step(); bor_i = 0;
    wdt_to_i = 1; step(); wdt_to_i = 0;
    mclr_ni = 0; step(); mclr_ni = 1; step(4);
    chk("R11 flags kept over bor/wdt/pin", {stk_unf_flag_o, stk_ovf_flag_o}, 3);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    chk("R11 sw clear", {stk_unf_flag_o, stk_ovf_flag_o}, 0);
    cfg_stk_rst_i = 0;
    stk_ovf_i = 1; flag_clr_i = 1; step(); stk_ovf_i = 0; flag_clr_i = 0;
    chk("R11 clear wins over set", stk_ovf_flag_o, 0);
    stk_unf_i = 1; step(); stk_unf_i = 0;
    por_i = 1; step(); por_i = 0;
    chk("R11 por clears", stk_unf_flag_o, 0);
    step(3);

    cur_tag = "R12";
    cfg_pwrup_dis_i = 0;
    por_i = 1; step(); por_i = 0;
    step(3);
    bor_i = 1; step(); bor_i = 0;
    measure(len); chk("R12 delay restarted", len, N_DLY + 1);

    step(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule